// File: doc/BRIEF.md
# Decimal-Programmed Clock Divider

This block divides its clock by a ratio N that is set in decimal. Each decade of the divider has its own 4-bit BCD digit input, and N is the number those digits spell. Every decade is a down-counter, and all decades share one clock. A decade takes a step only when every decade below it reads zero, so together the decades count down through the whole decimal number. When all decades read zero, the next edge loads the digits again. The output is an active-low pulse one clock wide, and it appears once every N input clocks.

A controlling state machine has three states. ST_PRIME lasts one cycle after reset. ST_COUNT is the state in which the chain runs. ST_STOPPED is held while the programmed value is zero. The transitions are:
- T_START: from ST_PRIME to ST_COUNT, when the digits are nonzero.
- T_IDLE: from ST_PRIME to ST_STOPPED, when the digits are zero.
- T_STEP: from ST_COUNT to ST_COUNT, while the chain is above zero.
- T_RELOAD: from ST_COUNT to ST_COUNT, when the chain is at zero and the digits are nonzero.
- T_HALT: from ST_COUNT to ST_STOPPED, when the chain is at zero and the digits are zero.
- T_WAIT: from ST_STOPPED to ST_STOPPED, while the digits stay zero.
- T_RESUME: from ST_STOPPED to ST_COUNT, when the digits become nonzero.

When the digits are sampled, the chain is loaded with the BCD value N−1 rather than N. This makes each period exactly N edges long, counting the load edge as one of them. The output comes straight from a flop, so edge-sensitive logic that follows can use it without gating it with the clock.

Top module: `freq_decade_divider`

## Requirements
- R1: While rst_i is high at a rising edge, pulse_n_o is high after that edge and the state returns to ST_PRIME. The first edge with rst_i low samples digits_i.
- R2: digits_i[4i+3:4i] holds decade i, where i=0 is the units decade, and each digit is a value from 0 to 9. N is the sum of d_i·10^i. If the digits are sampled at edge k and N≥1, pulse_n_o is low for the one cycle after edge k+N−1, and the digits are sampled again at edge k+N. This gives one low cycle every N clocks.
- R3: For N≥2, each low pulse lasts exactly one cycle and is followed by high. For N=1, pulse_n_o is low in every cycle.
- R4: If the digits are sampled as zero, no counting takes place and pulse_n_o stays high. While stopped, the digits are sampled at every edge. Nonzero digits seen at edge k start the period of R2 from edge k.
- R5: A change of digits_i between two sample edges has no effect on the period already in progress. The new value is used from the next sample edge.
- R6: A decade steps only when counting is enabled and every lower decade reads zero. No decade leaves the range 0 to 9, and the top decade never wraps. This means ratios that cross decade boundaries (10, 99, 100, 907) follow R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| digits_i | input | 4*DECADES | BCD ratio digits; bits [3:0] hold the units decade |
| pulse_n_o | output | 1 | Divided output, low for one clock per period; held high when N=0 |

## Verification
After reset is released, the first edge is the load edge. The first low pulse is due in the cycle after edge N, counted from that release, and each later pulse follows exactly N edges after the one before it. Digits that become nonzero while the block is stopped are sampled at the very next edge, so their first pulse falls N−1 edges after that. For each setting, the driver pushes the edge index at which every low pulse is due into a queue. The monitor samples on the falling clock, pops an entry for every low cycle it sees, and compares it with the bench's own edge count. A low cycle that nothing expects counts as a failure, and so does an entry still waiting in the queue when the setting ends.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    typedef enum logic [1:0] {
        ST_PRIME   = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STOPPED = 2'd2
    } div_state_e;

    // One BCD down-step; zero borrows and becomes nine
    function automatic logic [DIGIT_W-1:0] digit_down(input logic [DIGIT_W-1:0] d);
        return (d == '0) ? DIGIT_MAX : d - DIGIT_W'(1);
    endfunction

endpackage

// File: rtl/fdiv_decade_stage.sv
module fdiv_decade_stage
    import fdiv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [DIGIT_W-1:0] load_val_i,
    input  logic               step_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               tc_n_o
);

    logic [DIGIT_W-1:0] digit_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            digit_q <= '0;
        end else if (load_i) begin
            digit_q <= load_val_i;
        end else if (step_i) begin
            digit_q <= digit_down(digit_q);
        end
    end

    // Active-low borrow: this decade is stepping through zero
    assign tc_n_o  = !(step_i && (digit_q == '0));
    assign digit_o = digit_q;

endmodule

// File: rtl/fdiv_preset_dec.sv
module fdiv_preset_dec
    import fdiv_pkg::*;
#(
    parameter int DECADES = 3
) (
    input  logic [DECADES*DIGIT_W-1:0] digits_i,
    output logic [DECADES*DIGIT_W-1:0] value_o,
    output logic                       zero_o,
    output logic                       one_o
);

    localparam int VEC_W = DECADES * DIGIT_W;
    localparam logic [VEC_W-1:0] ONE_PATTERN = VEC_W'(1);

    logic [DECADES-1:0] borrow;
    logic [VEC_W-1:0]   value_raw;

    for (genvar i = 0; i < DECADES; i++) begin : g_digit
        if (i == 0) begin : g_lsd
            assign borrow[i] = 1'b1;
        end
        assign value_raw[i*DIGIT_W +: DIGIT_W] =
            borrow[i] ? digit_down(digits_i[i*DIGIT_W +: DIGIT_W])
                      : digits_i[i*DIGIT_W +: DIGIT_W];
        if (i < DECADES - 1) begin : g_carry
            assign borrow[i+1] = borrow[i] && (digits_i[i*DIGIT_W +: DIGIT_W] == '0);
        end
    end

    assign zero_o  = (digits_i == '0);
    assign one_o   = (digits_i == ONE_PATTERN);
    // A zero setting loads a cleared chain instead of wrapping to all nines
    assign value_o = zero_o ? '0 : value_raw;

endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
    import fdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       chain_zero_i,
    input  logic       chain_one_i,
    input  logic       preset_zero_i,
    input  logic       preset_one_i,
    output logic       load_o,
    output logic       count_en_o,
    output logic       pulse_n_o,
    output div_state_e state_o
);

    div_state_e state_q;
    div_state_e state_d;
    logic       pulse_n_q;
    logic       next_zero;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: begin
                state_d = preset_zero_i ? ST_STOPPED : ST_COUNT;      // T_IDLE / T_START
            end
            ST_COUNT: begin
                if (!chain_zero_i) begin
                    state_d = ST_COUNT;                               // T_STEP
                end else if (preset_zero_i) begin
                    state_d = ST_STOPPED;                             // T_HALT
                end else begin
                    state_d = ST_COUNT;                               // T_RELOAD
                end
            end
            ST_STOPPED: begin
                state_d = preset_zero_i ? ST_STOPPED : ST_COUNT;      // T_WAIT / T_RESUME
            end
            default: begin
                state_d = ST_PRIME;
            end
        endcase
    end

    // Digits are sampled outside ST_COUNT and whenever the chain sits at zero
    assign load_o     = (state_q != ST_COUNT) || chain_zero_i;
    assign count_en_o = (state_q == ST_COUNT) && !chain_zero_i;

    // Look ahead to the chain value after this edge so the output is a flop
    assign next_zero = load_o ? preset_one_i : chain_one_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_n_q <= 1'b1;
        end else begin
            pulse_n_q <= !((state_d == ST_COUNT) && next_zero);
        end
    end

    assign pulse_n_o = pulse_n_q;
    assign state_o   = state_q;

endmodule

// File: rtl/freq_decade_divider.sv
module freq_decade_divider
    import fdiv_pkg::*;
#(
    parameter int DECADES = 3
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [DECADES*DIGIT_W-1:0] digits_i,
    output logic                       pulse_n_o
);

    localparam int CHAIN_W = DECADES * DIGIT_W;
    localparam logic [CHAIN_W-1:0] CHAIN_ONE = CHAIN_W'(1);

    logic [CHAIN_W-1:0] preset_val;
    logic [CHAIN_W-1:0] chain_q;
    logic [DECADES-1:0] step;
    logic [DECADES-1:0] tc_n;
    logic               preset_zero;
    logic               preset_one;
    logic               chain_zero;
    logic               chain_one;
    logic               load;
    logic               count_en;
    div_state_e         state;

    fdiv_preset_dec #(
        .DECADES(DECADES)
    ) u_preset (
        .digits_i(digits_i),
        .value_o (preset_val),
        .zero_o  (preset_zero),
        .one_o   (preset_one)
    );

    for (genvar i = 0; i < DECADES; i++) begin : g_decade
        if (i == 0) begin : g_head
            assign step[i] = count_en;
        end else begin : g_link
            assign step[i] = !tc_n[i-1];
        end
        fdiv_decade_stage u_stage (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .load_i    (load),
            .load_val_i(preset_val[i*DIGIT_W +: DIGIT_W]),
            .step_i    (step[i]),
            .digit_o   (chain_q[i*DIGIT_W +: DIGIT_W]),
            .tc_n_o    (tc_n[i])
        );
    end

    assign chain_zero = (chain_q == '0);
    assign chain_one  = (chain_q == CHAIN_ONE);

    fdiv_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .chain_zero_i (chain_zero),
        .chain_one_i  (chain_one),
        .preset_zero_i(preset_zero),
        .preset_one_i (preset_one),
        .load_o       (load),
        .count_en_o   (count_en),
        .pulse_n_o    (pulse_n_o),
        .state_o      (state)
    );

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
    import fdiv_pkg::*;
#(
    parameter int DECADES = 3
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic                       pulse_n_i,
    input div_state_e                 state_i,
    input logic [DECADES*DIGIT_W-1:0] chain_i,
    input logic                       chain_zero_i,
    input logic                       preset_one_i,
    input logic [DECADES-1:0]         tc_n_i
);

    function automatic bit chain_legal(input logic [DECADES*DIGIT_W-1:0] v);
        for (int i = 0; i < DECADES; i++) begin
            if (v[i*DIGIT_W +: DIGIT_W] > DIGIT_MAX) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R1
    reset_high_chk: assert property (@(posedge clk_i) rst_i |=> pulse_n_i);

    // R4
    stopped_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_STOPPED) |-> pulse_n_i);

    // R2
    low_at_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !pulse_n_i |-> (state_i == ST_COUNT && chain_zero_i));

    // R3
    single_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pulse_n_i && !preset_one_i) |=> pulse_n_i);

    // R5
    no_early_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_COUNT && !chain_zero_i) |=> (state_i == ST_COUNT));

    // R6
    chain_bcd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        chain_legal(chain_i));

    // R6
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_n_i[DECADES-1]);

endmodule

bind freq_decade_divider fdiv_checker #(.DECADES(DECADES)) u_checker (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pulse_n_i   (pulse_n_o),
    .state_i     (state),
    .chain_i     (chain_q),
    .chain_zero_i(chain_zero),
    .preset_one_i(preset_one),
    .tc_n_i      (tc_n)
);

// File: tb/tb_freq_decade_divider.sv
module tb_freq_decade_divider;

    localparam int DECADES = 3;
    localparam int W       = DECADES * 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] digits = '0;
    logic         pulse_n;

    int    total = 0;
    int    bad   = 0;
    int    rel   = 0;
    int    cyc   = 0;
    bit    mon_on = 1'b0;
    string mon_tag = "";
    int    exp_q[$];

    always #2 clk = ~clk;

    freq_decade_divider #(.DECADES(DECADES)) dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .digits_i (digits),
        .pulse_n_o(pulse_n)
    );

    // rel counts rising edges since reset was released
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) rel <= 0;
        else     rel <= rel + 1;
    end

    function automatic logic [W-1:0] to_bcd(input int n);
        logic [W-1:0] r;
        int v;
        r = '0;
        v = n;
        for (int i = 0; i < DECADES; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: every low cycle must match the next expected edge index
    always @(negedge clk) begin
        if (mon_on && !pulse_n) begin
            int e;
            if (exp_q.size() == 0) begin
                check(1'b0, {mon_tag, " unexpected low"}, rel, -1);
            end else begin
                e = exp_q.pop_front();
                check(rel == e, mon_tag, rel, e);
            end
        end
    end

    task automatic wait_rel(input int r);
        while (rel < r) @(negedge clk);
    endtask

    task automatic start_phase(input int n, input string tag);
        @(negedge clk);
        rst     = 1'b1;
        mon_on  = 1'b0;
        digits  = to_bcd(n);
        exp_q.delete();
        mon_tag = tag;
        @(negedge clk);
        check(pulse_n == 1'b1, "R1 output high in reset", pulse_n, 1);
        @(negedge clk);
        rst    = 1'b0;
        mon_on = 1'b1;
    endtask

    task automatic end_phase(input int last_rel);
        wait_rel(last_rel);
        #1;
        check(exp_q.size() == 0, {mon_tag, " missing pulses"}, exp_q.size(), 0);
        mon_on = 1'b0;
    endtask

    task automatic run_fixed(input int n, input int periods, input string tag);
        start_phase(n, tag);
        for (int m = 1; m <= periods; m++) exp_q.push_back(n * m);
        if (n >= 2) begin
            wait_rel(n + 1);
            #1;
            check(pulse_n == 1'b1, "R3 pulse one cycle wide", pulse_n, 1);
        end
        end_phase(n * periods);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        run_fixed(1,   6, "R3 ratio 1");
        run_fixed(9,   4, "R2 ratio 9");
        run_fixed(10,  4, "R6 ratio 10");
        run_fixed(99,  3, "R6 ratio 99");
        run_fixed(100, 2, "R6 ratio 100");
        run_fixed(907, 2, "R6 ratio 907");
        run_fixed(37,  3, "R2 ratio 37");

        // R4: zero holds high; nonzero digits are sampled on the next edge
        start_phase(0, "R4 zero setting");
        wait_rel(20);
        #1;
        check(pulse_n == 1'b1, "R4 held high at zero", pulse_n, 1);
        wait_rel(50);
        #1;
        check(pulse_n == 1'b1, "R4 still high at zero", pulse_n, 1);
        digits = to_bcd(3);
        exp_q.push_back(53);
        exp_q.push_back(56);
        exp_q.push_back(59);
        end_phase(59);

        // R5: a mid-period change waits for the reload edge
        start_phase(25, "R5 mid-period change");
        exp_q.push_back(25);
        wait_rel(10);
        #1;
        digits = to_bcd(7);
        exp_q.push_back(32);
        exp_q.push_back(39);
        exp_q.push_back(46);
        end_phase(46);

        // R4: dropping to zero while counting stops at the next reload
        start_phase(4, "R4 stop after reload");
        exp_q.push_back(4);
        wait_rel(2);
        #1;
        digits = '0;
        wait_rel(30);
        #1;
        check(pulse_n == 1'b1, "R4 stopped after zero reload", pulse_n, 1);
        end_phase(31);

        summary();
        $finish;
    end

endmodule